// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Free-Run Mode

This block is a programmable watchdog built around a wide down-counter that advances once per system clock. Software programs two short preload values through a small synchronous register port. Each preload is placed into the counter at one of two bit positions, chosen by a scale bit. The placement gives a coarse or a fine time base without a separate prescaler.

In watchdog mode, enabling the block starts the first stage. Software keeps the block alive by writing to a kick register. If it fails to kick in time, the first stage expires. The block then raises a one-cycle interrupt request, records an interrupt flag and starts a second, independently timed stage. A kick during the second stage sends the block back to the first stage. If the second stage also runs out, the block sets a sticky trip flag and latches the timeout pin, which can drive a system reset.

In free-running mode the block ignores the first preload and the kick register. It reloads the second preload each time the counter runs out and toggles the timeout pin, so it acts as a square-wave source. This toggling is also the only way, other than reset, to drop a latched timeout pin.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the control register reads 0, both preloads read all ones, the status register reads 0, the counter reads 0, `irq_req` and `tmo_out` are 0 and `tmo_oe` is 1.
- R2: A preload value p is loaded into the counter as p shifted left by CNT_W-PRE_W when the scale bit (control bit 2) is 0, and shifted left by SHIFT_FAST when it is 1. All other counter bits are zero. The counter read address (5) returns the counter's top PRE_W bits.
- R3: Writing the control register with run (bit 0) set and free (bit 1) clear starts stage one, with value V loaded one cycle after the write. The stage-one expiry comes V+2 edges after the write edge. It pulses `irq_req` for exactly one cycle and sets status bit 0 in that same cycle.
- R4: A write of any data to the kick address (4) during stage one reloads preload one at that edge. Stage one then expires V+1 edges later. A kick takes priority over an expiry in the same cycle.
- R5: A kick during stage two returns the block to stage one with preload one reloaded, and the pending trip does not occur.
- R6: Stage two, loaded with value W at the stage-one expiry edge, expires W+1 edges later. It sets status bit 1, drives the latched timeout state to 1 and raises no interrupt. The counter then stops until a kick or a disable.
- R7: In free mode (control bits 1 and 0 set), the counter loads preload two one cycle after the start write. The timeout state toggles every W+1 edges, starting W+2 edges after the write. Kicks and preload one have no effect, and no interrupt or status bit 0 is produced.
- R8: When the mask bit (control bit 3) is 1, `tmo_oe` is 0 and `tmo_out` is 0. When it is 0, `tmo_oe` is 1 and `tmo_out` shows the timeout state.
- R9: Writing 1 to status bit 0 or bit 1 (address 3) clears it. Clearing bit 1 leaves the timeout state latched; only reset or a free-mode toggle lowers it.
- R10: `irq_kind` always equals control bits 5:4. Encodings 0, 1 and 2 name three interrupt delivery types and are passed through unchanged.
- R11: Clearing the run bit stops the counter and idles the stages, with no later interrupt or trip. The timeout state is kept. A later start begins from the full stage-one timeout.
- R12: While the run bit is 1, writes to the free bit, the scale bit and both preload registers (addresses 1 and 2) are ignored. While the run bit is 0, they are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances once per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_wr | input | 1 | Write strobe, one write per cycle high |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_req | output | 1 | One-cycle pulse at stage-one expiry |
| irq_kind | output | 2 | Interrupt delivery type code from control bits 5:4 |
| tmo_out | output | 1 | Timeout pin value, 0 while masked |
| tmo_oe | output | 1 | Timeout pin drive enable, low while masked |

## Verification
The bench builds the block with a 12-bit counter, 4-bit preloads and a fine shift of 2. The coarse scale therefore multiplies a preload by 256 and the fine scale by 4. With these values every stage runs out within a few hundred to about a thousand cycles. The bench sweeps small preload pairs across both scales and checks each expiry at its exact edge. The same small widths let it also drive kicks at chosen points in both stages, a long free-run toggle train, and recovery of a latched pin without long runs.

// File: rtl/wdog_pkg.sv
// Shared types for the two-stage watchdog.
// Assumes a 3-bit register address space; control layout is fixed here.
package wdog_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOADA = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOADB = 3'd2;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd3;
    localparam logic [ADDR_W-1:0] A_KICK  = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;

    localparam int CTRL_W = 6;

    // Control register, LSB is run.
    typedef struct packed {
        logic [1:0] kind;   // [5:4] interrupt delivery type
        logic       mask;   // [3]   1 = timeout pin not driven
        logic       fine;   // [2]   1 = fine placement of preload
        logic       free;   // [1]   1 = free-running square wave
        logic       run;    // [0]   1 = counting
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_GRACE = 3'd2,
        ST_TRIP  = 3'd3,
        ST_FREE  = 3'd4
    } stage_e;

endpackage

// File: rtl/wdog_regs.sv
// Register file of the watchdog: control, two preloads, write-1-to-clear
// flags, kick strobe and combinational read mux.
// Assumes DATA_W is wider than both PRE_W and the control width.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int PRE_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              set_flag1,
    input  logic              set_trip,
    input  logic [PRE_W-1:0]  snap,
    output ctrl_t             ctrl,
    output logic [PRE_W-1:0]  pre_a,
    output logic [PRE_W-1:0]  pre_b,
    output logic              kick,
    output logic [DATA_W-1:0] rdata
);

    localparam int USE_W = (PRE_W > CTRL_W) ? PRE_W : CTRL_W;

    logic flag1;
    logic trip;
    logic wr_ctrl, wr_a, wr_b, wr_flags;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^wdata[DATA_W-1:USE_W];

    // Decode the write strobes per register.
    always_comb begin
        wr_ctrl  = wr_en && (addr == A_CTRL);
        wr_a     = wr_en && (addr == A_LOADA);
        wr_b     = wr_en && (addr == A_LOADB);
        wr_flags = wr_en && (addr == A_FLAGS);
        kick     = wr_en && (addr == A_KICK);
    end

    // Control register; mode and scale frozen while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.run  <= wdata[0];
            ctrl.mask <= wdata[3];
            ctrl.kind <= wdata[5:4];
            if (!ctrl.run) begin
                ctrl.free <= wdata[1];
                ctrl.fine <= wdata[2];
            end
        end
    end

    // Preload registers, writable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_a <= '1;
            pre_b <= '1;
        end else if (!ctrl.run) begin
            if (wr_a) pre_a <= wdata[PRE_W-1:0];
            if (wr_b) pre_b <= wdata[PRE_W-1:0];
        end
    end

    // Status flags: hardware set wins over a write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag1 <= 1'b0;
            trip  <= 1'b0;
        end else begin
            flag1 <= set_flag1 | (flag1 & ~(wr_flags & wdata[0]));
            trip  <= set_trip  | (trip  & ~(wr_flags & wdata[1]));
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata[CTRL_W-1:0] = ctrl;
            A_LOADA: rdata[PRE_W-1:0]  = pre_a;
            A_LOADB: rdata[PRE_W-1:0]  = pre_b;
            A_FLAGS: rdata[1:0]        = {trip, flag1};
            A_COUNT: rdata[PRE_W-1:0]  = snap;
            default: rdata             = '0;
        endcase
    end

    // R12
    preload_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && $past(ctrl.run)) |-> ($stable(pre_a) && $stable(pre_b)));

    // R12
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && $past(ctrl.run)) |-> ($stable(ctrl.free) && $stable(ctrl.fine)));

    // R6
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !(wr_en && addr == A_FLAGS && wdata[1])) |=> trip);

endmodule

// File: rtl/wdog_ctr.sv
// Down-counter of the watchdog. Loads a preload placed at a coarse or fine
// bit position, decrements while running, reports zero and a top-bit snapshot.
// Assumes SHIFT_FAST + PRE_W <= CNT_W.
module wdog_ctr #(
    parameter int CNT_W      = 35,
    parameter int PRE_W      = 20,
    parameter int SHIFT_FAST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sel_b,
    input  logic             fine,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_a,
    input  logic [PRE_W-1:0] pre_b,
    output logic             zero,
    output logic [PRE_W-1:0] snap
);

    localparam int SHIFT_SLOW = CNT_W - PRE_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ext;
    logic [CNT_W-1:0] load_val;

    // Place the selected preload at the scale-dependent position.
    always_comb begin
        ext      = CNT_W'(sel_b ? pre_b : pre_a);
        load_val = fine ? (ext << SHIFT_FAST) : (ext << SHIFT_SLOW);
    end

    // Counter register: load has priority, then decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign zero = (cnt == '0);
    assign snap = cnt[CNT_W-1 -: PRE_W];

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));

endmodule

// File: rtl/wdog_seq.sv
// Stage sequencer of the watchdog: picks what to load, when to interrupt,
// when to trip and when to toggle the timeout state.
// Assumes the counter reports zero for the value it holds this cycle.
module wdog_seq
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_en,
    input  logic   free_mode,
    input  logic   kick,
    input  logic   zero,
    output logic   load,
    output logic   sel_b,
    output logic   cnt_run,
    output logic   set_flag1,
    output logic   set_trip,
    output logic   irq,
    output logic   out_state
);

    stage_e stage, stage_nxt;
    logic   toggle;

    // Next stage and load control.
    always_comb begin
        stage_nxt = stage;
        load      = 1'b0;
        sel_b     = 1'b0;
        set_flag1 = 1'b0;
        set_trip  = 1'b0;
        toggle    = 1'b0;
        if (!run_en) begin
            stage_nxt = ST_IDLE;
        end else begin
            unique case (stage)
                ST_IDLE: begin
                    load = 1'b1;
                    if (free_mode) begin
                        sel_b     = 1'b1;
                        stage_nxt = ST_FREE;
                    end else begin
                        stage_nxt = ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (kick) begin
                        load = 1'b1;
                    end else if (zero) begin
                        load      = 1'b1;
                        sel_b     = 1'b1;
                        set_flag1 = 1'b1;
                        stage_nxt = ST_GRACE;
                    end
                end
                ST_GRACE: begin
                    if (kick) begin
                        load      = 1'b1;
                        stage_nxt = ST_ARM;
                    end else if (zero) begin
                        set_trip  = 1'b1;
                        stage_nxt = ST_TRIP;
                    end
                end
                ST_TRIP: begin
                    if (kick) begin
                        load      = 1'b1;
                        stage_nxt = ST_ARM;
                    end
                end
                ST_FREE: begin
                    if (zero) begin
                        load   = 1'b1;
                        sel_b  = 1'b1;
                        toggle = 1'b1;
                    end
                end
                default: stage_nxt = ST_IDLE;
            endcase
        end
    end

    assign cnt_run = (stage == ST_ARM) || (stage == ST_GRACE) || (stage == ST_FREE);

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= ST_IDLE;
        else        stage <= stage_nxt;
    end

    // One-cycle interrupt pulse at stage-one expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= set_flag1;
    end

    // Timeout state: set by a trip, flipped by free-run expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_state <= 1'b0;
        else if (set_trip) out_state <= 1'b1;
        else if (toggle)   out_state <= ~out_state;
    end

    // R3
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    free_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_FREE) |-> !irq);

    // R6
    out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_state) |-> ($past(stage) == ST_GRACE || $past(stage) == ST_FREE));

    // R9
    trip_holds_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_TRIP) |-> out_state);

endmodule

// File: rtl/wdog_two_stage.sv
// Top of the two-stage watchdog: register file, placed down-counter and
// stage sequencer, plus the masking of the timeout pin.
// Assumes a single clock; all inputs synchronous to it.
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 35,
    parameter int PRE_W      = 20,
    parameter int SHIFT_FAST = 5,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [1:0]        irq_kind,
    output logic              tmo_out,
    output logic              tmo_oe
);

    ctrl_t            ctrl;
    logic [PRE_W-1:0] pre_a, pre_b, snap;
    logic             kick, zero, load, sel_b, cnt_run;
    logic             set_flag1, set_trip, out_state;

    wdog_regs #(.PRE_W(PRE_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .wr_en(reg_wr), .set_flag1(set_flag1), .set_trip(set_trip),
        .snap(snap), .ctrl(ctrl), .pre_a(pre_a), .pre_b(pre_b),
        .kick(kick), .rdata(reg_rdata)
    );

    wdog_ctr #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SHIFT_FAST(SHIFT_FAST)) ctr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .sel_b(sel_b),
        .fine(ctrl.fine), .run(cnt_run), .pre_a(pre_a), .pre_b(pre_b),
        .zero(zero), .snap(snap)
    );

    wdog_seq seq_i (
        .clk(clk), .rst_n(rst_n), .run_en(ctrl.run), .free_mode(ctrl.free),
        .kick(kick), .zero(zero), .load(load), .sel_b(sel_b),
        .cnt_run(cnt_run), .set_flag1(set_flag1), .set_trip(set_trip),
        .irq(irq_req), .out_state(out_state)
    );

    // Pin masking and interrupt type pass-through.
    always_comb begin
        tmo_oe   = ~ctrl.mask;
        tmo_out  = out_state & ~ctrl.mask;
        irq_kind = ctrl.kind;
    end

endmodule

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;

    localparam int CW = 12;
    localparam int PW = 4;
    localparam int SF = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic          irq_req;
    logic [1:0]    irq_kind;
    logic          tmo_out, tmo_oe;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdog_two_stage #(.CNT_W(CW), .PRE_W(PW), .SHIFT_FAST(SF), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_kind(irq_kind), .tmo_out(tmo_out), .tmo_oe(tmo_oe)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    function automatic int place(input int p, input int fine);
        return fine != 0 ? (p << SF) : (p << (CW - PW));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        int v, w;

        do_reset();
        // R1 reset state
        rd(3'd0, d); chk("R1 ctrl", d, 0);
        rd(3'd1, d); chk("R1 preload a", d, 15);
        rd(3'd2, d); chk("R1 preload b", d, 15);
        rd(3'd3, d); chk("R1 status", d, 0);
        rd(3'd5, d); chk("R1 count", d, 0);
        chk("R1 irq", irq_req, 0);
        chk("R1 tmo_out", tmo_out, 0);
        chk("R1 tmo_oe", tmo_oe, 1);

        // R10 interrupt type field sweep
        for (int k = 0; k < 4; k++) begin
            wr(3'd0, DW'(k << 4));
            chk("R10 irq_kind", irq_kind, k);
        end

        // R2 R3 R6 R9 sweep over preloads and both scales
        for (int f = 0; f < 2; f++) begin
            for (int p = 1; p <= 3; p++) begin
                for (int q = 1; q <= 2; q++) begin
                    do_reset();
                    v = place(p, f);
                    w = place(q, f);
                    wr(3'd1, DW'(p));
                    wr(3'd2, DW'(q));
                    wr(3'd0, DW'(1 | (f << 2)));
                    step(1);
                    rd(3'd5, d); chk("R2 snapshot after load", d, v >> (CW - PW));
                    step(v);
                    chk("R3 no early irq", irq_req, 0);
                    rd(3'd3, d); chk("R3 no early flag", d, 0);
                    step(1);
                    chk("R3 irq at expiry", irq_req, 1);
                    rd(3'd3, d); chk("R3 flag set", d, 1);
                    step(1);
                    chk("R3 irq one cycle", irq_req, 0);
                    step(w - 1);
                    chk("R6 no early trip", tmo_out, 0);
                    step(1);
                    chk("R6 trip pin", tmo_out, 1);
                    chk("R6 no irq on trip", irq_req, 0);
                    rd(3'd3, d); chk("R6 trip flag", d, 3);
                    wr(3'd3, 32'h3);
                    rd(3'd3, d); chk("R9 flags cleared", d, 0);
                    chk("R9 pin stays latched", tmo_out, 1);
                    step(40);
                    rd(3'd5, d); chk("R6 counter stopped", d, 0);
                    chk("R6 no later irq", irq_req, 0);
                end
            end
        end

        // R4 R5 R11 kicks in both stages, then disable
        do_reset();
        wr(3'd1, 32'd3);          // V = 12
        wr(3'd2, 32'd1);          // W = 4
        wr(3'd0, 32'h5);          // edge 0
        step(6);
        wr(3'd4, 32'h0);          // kick at edge 7
        step(12);
        chk("R4 no irq before reloaded expiry", irq_req, 0);
        step(1);
        chk("R4 irq after reloaded timeout", irq_req, 1);
        step(2);
        wr(3'd4, 32'h0);          // kick in stage two at edge 23
        step(2);
        chk("R5 trip cancelled", tmo_out, 0);
        step(10);
        chk("R5 back in stage one no irq yet", irq_req, 0);
        step(1);
        chk("R5 stage one expires again", irq_req, 1);
        wr(3'd0, 32'h4);          // disable during stage two
        step(100);
        chk("R11 no trip after disable", tmo_out, 0);
        chk("R11 no irq after disable", irq_req, 0);
        wr(3'd0, 32'h5);
        step(13);
        chk("R11 restart full timeout no irq", irq_req, 0);
        step(1);
        chk("R11 restart irq", irq_req, 1);

        // R7 R8 free-running mode
        do_reset();
        wr(3'd1, 32'd3);
        wr(3'd2, 32'd2);          // W = 8
        wr(3'd0, 32'h7);          // edge 0, toggles at 10, 19, 28
        step(9);
        chk("R7 before first toggle", tmo_out, 0);
        step(1);
        chk("R7 first toggle", tmo_out, 1);
        step(8);
        chk("R7 holds between toggles", tmo_out, 1);
        step(1);
        chk("R7 second toggle", tmo_out, 0);
        wr(3'd4, 32'h0);          // kick ignored at edge 20
        step(7);
        chk("R7 kick ignored", tmo_out, 0);
        step(1);
        chk("R7 third toggle", tmo_out, 1);
        chk("R7 no irq", irq_req, 0);
        rd(3'd3, d); chk("R7 no flag", d, 0);
        wr(3'd0, 32'hF);          // mask
        chk("R8 masked oe", tmo_oe, 0);
        chk("R8 masked out", tmo_out, 0);
        wr(3'd0, 32'h7);          // unmask
        chk("R8 unmasked oe", tmo_oe, 1);
        chk("R8 unmasked out", tmo_out, 1);

        // R9 R11 recovery of a latched pin through free mode
        do_reset();
        wr(3'd1, 32'd1);
        wr(3'd2, 32'd1);          // V = W = 4
        wr(3'd0, 32'h5);
        step(11);
        chk("R9 tripped", tmo_out, 1);
        wr(3'd3, 32'h2);
        chk("R9 clear keeps pin", tmo_out, 1);
        wr(3'd0, 32'h4);
        step(5);
        chk("R11 disable keeps pin", tmo_out, 1);
        wr(3'd0, 32'h7);
        step(5);
        chk("R9 pin before toggle", tmo_out, 1);
        step(1);
        chk("R9 toggle lowers pin", tmo_out, 0);

        // R12 write lock while running
        do_reset();
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h1);
        wr(3'd1, 32'd9);
        wr(3'd2, 32'd9);
        wr(3'd0, 32'h7);
        rd(3'd1, d); chk("R12 preload a locked", d, 2);
        rd(3'd2, d); chk("R12 preload b locked", d, 15);
        rd(3'd0, d); chk("R12 mode scale locked", d & 32'h7, 1);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'd9);
        rd(3'd1, d); chk("R12 preload accepted when stopped", d, 9);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule